// File: doc/BRIEF.md
# Event Performance Monitor Counter Unit

This block holds a small bank of up-counters that tally selected processor events for profiling. Each cycle the core presents a vector of event pulses, the current privilege level and a mark flag. Each counter picks one event line through its own local control word and adds one on every cycle where that line is high and no applicable freeze condition holds. The freeze conditions are an unconditional local stop, a stop while in supervisor or user mode, and a stop while the mark flag is low or high. A global control word can stop the whole bank at once.

Software uses a flat register port to program the control words and to preload counters. To be told after N events, software loads a counter with 2^31 minus N. When bit 31 of a counter whose condition-enable bit is set becomes 1, that is an enabled condition. The condition drives a level interrupt if the global interrupt enable is on. If the freeze-on-condition bit is on, the condition also sets the global freeze bit by itself, so that the sampled counts stay still while the handler runs. No interface in this block carries a data stream: the event, privilege and mark pins have no back-pressure and are sampled on every clock, and a register write always completes in the cycle it is presented.

Top module: `perf_counter_bank`

## Requirements
- R1: Register address = {region, index}, where index is the two low bits. Region 0 is the global word (index 0), region 1 the counters, region 2 local control A and region 3 local control B. Counters, control A and control B read back the last value written. A write lands on the clock edge where reg_we_i is high.
- R2: Control A bits [11:8] select the event line. At each enabled clock edge where the selected line of evt_i is high, the counter adds exactly one. Lines that are not selected have no effect.
- R3: Control A bit 1 stops counting while priv_sup_i is 1, and bit 2 stops counting while priv_sup_i is 0.
- R4: Control A bit 0 stops the counter unconditionally. Bit 3 stops it while mark_i is 0, and bit 4 stops it while mark_i is 1.
- R5: Global bit 0 (freeze-all) stops every counter, whatever the local settings.
- R6: A register write to a counter in the same cycle as a counting event takes priority, and that increment is lost.
- R7: irq_o = global bit 1 AND the OR over counters of (control A bit 5 AND counter bit 31). It stays high until software rewrites the counter so that bit 31 is clear, or turns off the enable.
- R8: While global bit 2 is set and an enabled condition is present, freeze-all is forced to 1 at the next edge. No counter increments after the edge at which the crossing happened.
- R9: Reset clears every counter and control B, loads every control A with 0x1F (all local freezes set), sets the global word to 0x1 (frozen, interrupt disabled), and leaves irq_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_EVENTS | Per-cycle event pulses |
| priv_sup_i | input | 1 | 1 = supervisor mode, 0 = user mode |
| mark_i | input | 1 | Mark state of the running context |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register address {region, index} |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Combinational read data for reg_addr_i |
| irq_o | output | 1 | Level interrupt for an enabled condition |

## Verification
Two functions can act on the same cycle. The first is a software write to a counter, which can land on the same edge as an event that would increment that counter. The bench provokes this by raising the selected event line and the write strobe in the same cycle, then reading back exactly the written value. The second is the crossing of bit 31 when the bank is set to freeze on a condition: the bench holds the event line high for several cycles past the crossing. It then requires the counter to read exactly 0x80000000 and the global word to show freeze-all set, both in the same run.

// File: rtl/perf_pkg.sv
package perf_pkg;
  // local control A bit positions
  localparam int A_FRZ     = 0;
  localparam int A_FRZ_SUP = 1;
  localparam int A_FRZ_USR = 2;
  localparam int A_FRZ_M0  = 3;
  localparam int A_FRZ_M1  = 4;
  localparam int A_CEN     = 5;
  localparam int A_SEL_LSB = 8;
  // global control bit positions
  localparam int G_FRZ_ALL = 0;
  localparam int G_IRQ_EN  = 1;
  localparam int G_FOC     = 2;

  typedef enum logic [1:0] {
    RG_GLOBAL = 2'd0,
    RG_COUNT  = 2'd1,
    RG_CTLA   = 2'd2,
    RG_CTLB   = 2'd3
  } region_e;
endpackage

// File: rtl/perf_counter_slot.sv
module perf_counter_slot
  import perf_pkg::*;
#(
  parameter int DW = 32,
  parameter int NUM_EVENTS = 16,
  localparam int SELW = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_EVENTS-1:0] evt_i,
  input  logic                  priv_sup_i,
  input  logic                  mark_i,
  input  logic                  halt_i,
  input  logic                  we_cnt_i,
  input  logic                  we_a_i,
  input  logic                  we_b_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         cnt_o,
  output logic [DW-1:0]         ctla_o,
  output logic [DW-1:0]         ctlb_o,
  output logic                  cond_o
);
  localparam logic [DW-1:0] CTLA_STOPPED = DW'(32'h1F);

  logic [DW-1:0]   cnt_q, ctla_q, ctlb_q;
  logic [SELW-1:0] sel;
  logic            evt_hit, gate_ok, inc;

  assign sel = ctla_q[A_SEL_LSB +: SELW];

  always_comb begin
    evt_hit = 1'b0;
    for (int k = 0; k < NUM_EVENTS; k++)
      if (sel == SELW'(k)) evt_hit = evt_i[k];
  end

  assign gate_ok = !halt_i
                 && !ctla_q[A_FRZ]
                 && !(ctla_q[A_FRZ_SUP] &&  priv_sup_i)
                 && !(ctla_q[A_FRZ_USR] && !priv_sup_i)
                 && !(ctla_q[A_FRZ_M0]  && !mark_i)
                 && !(ctla_q[A_FRZ_M1]  &&  mark_i);
  assign inc = gate_ok && evt_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ctla_q <= CTLA_STOPPED;
      ctlb_q <= '0;
    end else begin
      if (we_cnt_i)  cnt_q <= wdata_i;
      else if (inc)  cnt_q <= cnt_q + 1'b1;
      if (we_a_i)    ctla_q <= wdata_i;
      if (we_b_i)    ctlb_q <= wdata_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign ctla_o = ctla_q;
  assign ctlb_o = ctlb_q;
  assign cond_o = ctla_q[A_CEN] && cnt_q[DW-1];

  // R6: a counter write wins over a same-cycle increment
  a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    we_cnt_i |=> (cnt_q == $past(wdata_i)));
  // R5: a halted bank does not move without a write
  a_r5_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && !we_cnt_i) |=> $stable(cnt_q));
  // R3: user-mode freeze holds the count
  a_r3_user_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (ctla_q[A_FRZ_USR] && !priv_sup_i && !we_cnt_i) |=> $stable(cnt_q));
  // R7: condition persists until rewrite
  a_r7_cond_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_o && !we_cnt_i && !we_a_i && (cnt_q != '1)) |=> cond_o);
endmodule

// File: rtl/perf_global_ctrl.sv
module perf_global_ctrl
  import perf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          any_cond_i,
  output logic [DW-1:0] gctl_o,
  output logic          halt_o,
  output logic          irq_o
);
  logic frz_q, irq_en_q, foc_q, auto_frz;

  assign auto_frz = foc_q && any_cond_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frz_q    <= 1'b1;
      irq_en_q <= 1'b0;
      foc_q    <= 1'b0;
    end else begin
      if (we_i) begin
        frz_q    <= wdata_i[G_FRZ_ALL];
        irq_en_q <= wdata_i[G_IRQ_EN];
        foc_q    <= wdata_i[G_FOC];
      end
      if (auto_frz) frz_q <= 1'b1;
    end
  end

  always_comb begin
    gctl_o            = '0;
    gctl_o[G_FRZ_ALL] = frz_q;
    gctl_o[G_IRQ_EN]  = irq_en_q;
    gctl_o[G_FOC]     = foc_q;
  end

  assign halt_o = frz_q || auto_frz;
  assign irq_o  = irq_en_q && any_cond_i;

  // R8: a condition with freeze-on-condition forces freeze-all next edge
  a_r8_auto_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (foc_q && any_cond_i) |=> frz_q);
  // R5: freeze-all only clears through a write
  a_r5_frz_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frz_q) |-> $past(we_i));
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import perf_pkg::*;
#(
  parameter int NUM_CTR    = 4,
  parameter int NUM_EVENTS = 16,
  parameter int DW         = 32,
  localparam int IDXW = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1,
  localparam int AW   = IDXW + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_EVENTS-1:0] evt_i,
  input  logic                  priv_sup_i,
  input  logic                  mark_i,
  input  logic                  reg_we_i,
  input  logic [AW-1:0]         reg_addr_i,
  input  logic [DW-1:0]         reg_wdata_i,
  output logic [DW-1:0]         reg_rdata_o,
  output logic                  irq_o
);
  region_e         region;
  logic [IDXW-1:0] idx;
  logic [DW-1:0]   cnt_w  [NUM_CTR];
  logic [DW-1:0]   ctla_w [NUM_CTR];
  logic [DW-1:0]   ctlb_w [NUM_CTR];
  logic [NUM_CTR-1:0] cond_w;
  logic [DW-1:0]   gctl_w;
  logic            halt_w, any_cond;

  assign region   = region_e'(reg_addr_i[AW-1 -: 2]);
  assign idx      = reg_addr_i[IDXW-1:0];
  assign any_cond = |cond_w;

  perf_global_ctrl #(.DW(DW)) u_global (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (reg_we_i && region == RG_GLOBAL && idx == '0),
    .wdata_i    (reg_wdata_i),
    .any_cond_i (any_cond),
    .gctl_o     (gctl_w),
    .halt_o     (halt_w),
    .irq_o      (irq_o)
  );

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_slot
    logic hit;
    assign hit = reg_we_i && (idx == IDXW'(g));
    perf_counter_slot #(.DW(DW), .NUM_EVENTS(NUM_EVENTS)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_i),
      .priv_sup_i (priv_sup_i),
      .mark_i     (mark_i),
      .halt_i     (halt_w),
      .we_cnt_i   (hit && region == RG_COUNT),
      .we_a_i     (hit && region == RG_CTLA),
      .we_b_i     (hit && region == RG_CTLB),
      .wdata_i    (reg_wdata_i),
      .cnt_o      (cnt_w[g]),
      .ctla_o     (ctla_w[g]),
      .ctlb_o     (ctlb_w[g]),
      .cond_o     (cond_w[g])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int k = 0; k < NUM_CTR; k++) begin
      if (idx == IDXW'(k)) begin
        unique case (region)
          RG_COUNT: reg_rdata_o = cnt_w[k];
          RG_CTLA:  reg_rdata_o = ctla_w[k];
          RG_CTLB:  reg_rdata_o = ctlb_w[k];
          default:  reg_rdata_o = (k == 0) ? gctl_w : '0;
        endcase
      end
    end
  end

  // R9: interrupt low in the first cycle after reset
  a_r9_irq_reset: assert property (@(posedge clk)
    !rst_n |=> !irq_o);
  // R7: an interrupt requires a counter with an enabled condition
  a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cond_w != '0));
endmodule

// File: tb/test_perf_counter_bank.sv
module test_perf_counter_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NEV = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NEV-1:0]  evt = '0;
  logic            sup = 1'b0;
  logic            mark = 1'b0;
  logic            we = 1'b0;
  logic [3:0]      addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    string       tag;
    bit          is_irq;
    logic [31:0] exp;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_counter_bank i_perf_counter_bank (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .priv_sup_i(sup), .mark_i(mark),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      logic [31:0] act;
      e = sb.pop_front();
      act = e.is_irq ? {31'd0, irq} : rdata;
      checks++;
      if (act !== e.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", e.tag, act, e.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic expect_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    addr = a;
    sb.push_back('{tag, 1'b0, e});
    @(negedge clk);
  endtask

  task automatic expect_irq(input bit e, input string tag);
    @(posedge clk); #1;
    sb.push_back('{tag, 1'b1, {31'd0, e}});
    @(negedge clk);
  endtask

  task automatic pulse(input int line, input int n);
    @(posedge clk); #1;
    evt[line] = 1'b1;
    repeat (n) @(posedge clk);
    #1 evt[line] = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9 reset state
    expect_rd(4'h0, 32'h1, "R9 global");
    expect_rd(4'h8, 32'h1F, "R9 ctlA0");
    expect_rd(4'h4, 32'h0, "R9 cnt0");
    expect_rd(4'hC, 32'h0, "R9 ctlB0");
    expect_irq(1'b0, "R9 irq");
    // R2 basic counting on event line 3
    wr(4'h8, 32'h300);
    wr(4'h0, 32'h0);
    pulse(3, 5);
    expect_rd(4'h4, 32'd5, "R2 count five");
    pulse(2, 4);
    expect_rd(4'h4, 32'd5, "R2 other line ignored");
    // R5 freeze-all
    wr(4'h0, 32'h1);
    pulse(3, 3);
    expect_rd(4'h4, 32'd5, "R5 freeze-all holds");
    wr(4'h0, 32'h0);
    // R4 local unconditional freeze
    wr(4'h8, 32'h301);
    pulse(3, 2);
    expect_rd(4'h4, 32'd5, "R4 local freeze");
    // R3 privilege freezes
    wr(4'h8, 32'h302);
    sup = 1'b1;
    pulse(3, 4);
    expect_rd(4'h4, 32'd5, "R3 supervisor frozen");
    sup = 1'b0;
    pulse(3, 2);
    expect_rd(4'h4, 32'd7, "R3 user counts");
    wr(4'h8, 32'h304);
    pulse(3, 1);
    expect_rd(4'h4, 32'd7, "R3 user frozen");
    // R4 mark freezes
    wr(4'h8, 32'h310);
    mark = 1'b1;
    pulse(3, 3);
    expect_rd(4'h4, 32'd7, "R4 mark1 frozen");
    mark = 1'b0;
    pulse(3, 3);
    expect_rd(4'h4, 32'd10, "R4 mark0 counts");
    wr(4'h8, 32'h308);
    pulse(3, 2);
    expect_rd(4'h4, 32'd10, "R4 mark0 frozen");
    // R6 write vs same-cycle event
    wr(4'h8, 32'h300);
    @(posedge clk); #1;
    evt[3] = 1'b1; we = 1'b1; addr = 4'h4; wdata = 32'd100;
    @(posedge clk); #1;
    evt[3] = 1'b0; we = 1'b0;
    expect_rd(4'h4, 32'd100, "R6 write wins");
    // R1 control B and readback
    wr(4'hD, 32'hA5A5_0F0F);
    expect_rd(4'hD, 32'hA5A5_0F0F, "R1 ctlB1 readback");
    expect_rd(4'h8, 32'h300, "R1 ctlA0 readback");
    // R7 condition and interrupt
    wr(4'h0, 32'h2);
    wr(4'h9, 32'h120);
    wr(4'h5, 32'h7FFF_FFFE);
    expect_irq(1'b0, "R7 below crossing");
    pulse(1, 2);
    expect_rd(4'h5, 32'h8000_0000, "R7 counter crossed");
    expect_irq(1'b1, "R7 irq raised");
    repeat (3) @(posedge clk);
    expect_irq(1'b1, "R7 irq held");
    wr(4'h5, 32'h0);
    expect_irq(1'b0, "R7 irq cleared by rewrite");
    // R8 freeze on condition
    wr(4'h0, 32'h6);
    wr(4'h5, 32'h7FFF_FFFF);
    pulse(1, 4);
    expect_rd(4'h5, 32'h8000_0000, "R8 no count after crossing");
    expect_rd(4'h0, 32'h7, "R8 freeze-all set");
    expect_irq(1'b1, "R8 irq");
    wr(4'h5, 32'h0);
    wr(4'h0, 32'h2);
    expect_rd(4'h0, 32'h2, "R8 unfrozen after clear");
    // R7 no condition without enable bit
    wr(4'hA, 32'h000);
    wr(4'h6, 32'h7FFF_FFFF);
    pulse(0, 1);
    expect_rd(4'h6, 32'h8000_0000, "R7 ctr2 crossed");
    expect_irq(1'b0, "R7 no irq without cond enable");
    expect_rd(4'h7, 32'h0, "R4 reset-stopped ctr3 idle");
    repeat (2) @(posedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
    end
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule